// File: doc/BRIEF.md
# Banked Chip-Select Address Decoder

This block sits between the bus address path and a set of memory control engines. Software programs a small table of bank descriptors through a register-write port. Each descriptor holds a base tag, a size mask, a valid bit, the bus it answers to and the control engine that serves it. When an access request is accepted, the block compares the upper 17 bits of the 32-bit address with every descriptor. One clock later it presents a one-hot chip-select vector, a hit flag, the index of the winning bank and a code for the engine that should run the transfer.

Requests use a valid/ready handshake. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the cycle after `done_i` is pulsed, so a holding request waits and is not lost. The decode result stays frozen for the whole transfer, misses included. The downstream engine ends the transfer with `done_i`.

Register layout. In a base register, bits [31:15] hold the base tag and bit 0 is the valid bit. In an option register, bits [31:15] hold the size mask, bit 3 selects the bus (0 wide, 1 local) and bits [2:0] hold the engine code.

Top module: `bank_decoder`

## Requirements
- R1: A write with `wr_en`=1 stores `wr_data` into the base register (`wr_opt`=0) or the option register (`wr_opt`=1) of bank `wr_bank`. It is used by requests accepted in later cycles. It never changes the outputs of a transfer already accepted.
- R2: A bank matches when address bits [31:15] equal its base bits [31:15] in every position where its mask bit is 1. Address bits [14:0] never affect the result.
- R3: A bank whose base bit 0 (valid) is 0 never matches.
- R4: A bank matches only when its option bit 3 equals `req_bus` (0 wide bus, 1 local bus).
- R5: When several banks match, the lowest-numbered one wins. Exactly one `cs_o` bit is set, at that bank's index, and `bank_o` gives the index.
- R6: On a hit, `mach_o` equals option bits [2:0] of the winning bank: 000 general-purpose chip select, 001 SDRAM, 010/011/100 user machines A/B/C.
- R7: On a miss, `hit_o`=0, `cs_o`=0, `mach_o`=000 and `bank_o`=0.
- R8: A request accepted at a clock edge shows its result after that edge. `req_ready` is then low, and the outputs hold until `done_i` is sampled high.
- R9: A `done_i` pulse during a transfer clears `cs_o` and `hit_o` and raises `req_ready` at the next edge.
- R10: After reset, `cs_o`=0, `hit_o`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_opt | input | 1 | 0 selects base register, 1 selects option register |
| wr_bank | input | 4 | Bank number to write |
| wr_data | input | 32 | Register write data |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Decoder can accept a request |
| req_addr | input | 32 | Access address |
| req_bus | input | 1 | Requesting bus: 0 wide, 1 local |
| done_i | input | 1 | Transfer complete pulse |
| cs_o | output | 12 | One-hot chip selects |
| hit_o | output | 1 | A bank matched |
| mach_o | output | 3 | Engine code of the matched bank |
| bank_o | output | 4 | Index of the matched bank |

## Verification
The bench builds overlapping banks to test priority. A wrong encoder would raise two chip selects or pick a higher bank. It aims addresses just inside and just outside each mask, and changes the low 15 address bits. A decoder that compared too many bits, or ignored the mask, would flip hit and miss there. It sets up banks that are invalid or on the other bus while matching in every other way. These catch a design that drops the valid or bus qualifier. It also rewrites the live bank in the middle of a transfer and holds `done_i` low for a variable number of cycles. These catch a design that decodes combinationally from the registers, or one that releases early.

// File: rtl/bankdec_pkg.sv
package bankdec_pkg;
  typedef enum logic [2:0] {
    MACH_GPCS  = 3'b000,
    MACH_SDRAM = 3'b001,
    MACH_UPA   = 3'b010,
    MACH_UPB   = 3'b011,
    MACH_UPC   = 3'b100
  } mach_e;

  localparam int OPT_BUS_BIT   = 3;
  localparam int BASE_VLD_BIT  = 0;
  localparam int MACH_W        = 3;
endpackage

// File: rtl/bankdec_regs.sv
module bankdec_regs
  import bankdec_pkg::*;
#(
  parameter int NUM_BANKS = 12,
  parameter int ADDR_W    = 32,
  parameter int TAG_W     = 17,
  parameter int IDX_W     = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic                               wr_opt,
  input  logic [IDX_W-1:0]                   wr_bank,
  input  logic [ADDR_W-1:0]                  wr_data,
  output logic [NUM_BANKS-1:0][TAG_W-1:0]    base_tag,
  output logic [NUM_BANKS-1:0][TAG_W-1:0]    mask_tag,
  output logic [NUM_BANKS-1:0]               valid,
  output logic [NUM_BANKS-1:0]               bus_sel,
  output logic [NUM_BANKS-1:0][MACH_W-1:0]   mach
);
  localparam int LOW_W = ADDR_W - TAG_W;

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data[LOW_W-1:OPT_BUS_BIT+1];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = wr_en && (wr_bank == IDX_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_tag[b] <= '0;
        mask_tag[b] <= '0;
        valid[b]    <= 1'b0;
        bus_sel[b]  <= 1'b0;
        mach[b]     <= '0;
      end else if (sel && !wr_opt) begin
        base_tag[b] <= wr_data[ADDR_W-1 -: TAG_W];
        valid[b]    <= wr_data[BASE_VLD_BIT];
      end else if (sel && wr_opt) begin
        mask_tag[b] <= wr_data[ADDR_W-1 -: TAG_W];
        bus_sel[b]  <= wr_data[OPT_BUS_BIT];
        mach[b]     <= wr_data[MACH_W-1:0];
      end
    end
  end
endmodule

// File: rtl/bankdec_match.sv
module bankdec_match #(
  parameter int NUM_BANKS = 12,
  parameter int TAG_W     = 17
) (
  input  logic [TAG_W-1:0]                   addr_tag,
  input  logic                               bus,
  input  logic [NUM_BANKS-1:0][TAG_W-1:0]    base_tag,
  input  logic [NUM_BANKS-1:0][TAG_W-1:0]    mask_tag,
  input  logic [NUM_BANKS-1:0]               valid,
  input  logic [NUM_BANKS-1:0]               bus_sel,
  output logic [NUM_BANKS-1:0]               match
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cmp
    assign match[b] = valid[b] && (bus_sel[b] == bus) &&
                      (((addr_tag ^ base_tag[b]) & mask_tag[b]) == '0);
  end
endmodule

// File: rtl/bankdec_prio.sv
module bankdec_prio #(
  parameter int NUM_BANKS = 12,
  parameter int IDX_W     = 4
) (
  input  logic [NUM_BANKS-1:0] req,
  output logic                 found,
  output logic [IDX_W-1:0]     idx,
  output logic [NUM_BANKS-1:0] onehot
);
  always_comb begin
    idx    = '0;
    onehot = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx    = IDX_W'(i);
        onehot = NUM_BANKS'(1) << i;
      end
    end
  end
  assign found = |req;
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
  import bankdec_pkg::*;
#(
  parameter int NUM_BANKS = 12,
  parameter int ADDR_W    = 32,
  parameter int TAG_W     = 17,
  parameter int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_opt,
  input  logic [IDX_W-1:0]     wr_bank,
  input  logic [ADDR_W-1:0]    wr_data,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_bus,
  input  logic                 done_i,
  output logic [NUM_BANKS-1:0] cs_o,
  output logic                 hit_o,
  output logic [MACH_W-1:0]    mach_o,
  output logic [IDX_W-1:0]     bank_o
);
  localparam int LOW_W = ADDR_W - TAG_W;

  logic [NUM_BANKS-1:0][TAG_W-1:0]  base_tag, mask_tag;
  logic [NUM_BANKS-1:0]             valid, bus_sel, match, onehot;
  logic [NUM_BANKS-1:0][MACH_W-1:0] mach;
  logic                             found, busy;
  logic [IDX_W-1:0]                 idx;
  logic [MACH_W-1:0]                mach_sel;
  logic                             unused_addr_low;

  assign unused_addr_low = ^req_addr[LOW_W-1:0];

  bankdec_regs #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_opt(wr_opt), .wr_bank(wr_bank),
    .wr_data(wr_data), .base_tag(base_tag), .mask_tag(mask_tag), .valid(valid),
    .bus_sel(bus_sel), .mach(mach)
  );

  bankdec_match #(.NUM_BANKS(NUM_BANKS), .TAG_W(TAG_W)) u_match (
    .addr_tag(req_addr[ADDR_W-1 -: TAG_W]), .bus(req_bus), .base_tag(base_tag),
    .mask_tag(mask_tag), .valid(valid), .bus_sel(bus_sel), .match(match)
  );

  bankdec_prio #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_prio (
    .req(match), .found(found), .idx(idx), .onehot(onehot)
  );

  always_comb begin
    mach_sel = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      mach_sel |= mach[b] & {MACH_W{onehot[b]}};
    end
  end

  assign req_ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cs_o   <= '0;
      hit_o  <= 1'b0;
      mach_o <= '0;
      bank_o <= '0;
    end else if (busy && done_i) begin
      busy   <= 1'b0;
      cs_o   <= '0;
      hit_o  <= 1'b0;
      mach_o <= '0;
      bank_o <= '0;
    end else if (req_valid && !busy) begin
      busy   <= 1'b1;
      cs_o   <= onehot;
      hit_o  <= found;
      mach_o <= mach_sel;
      bank_o <= idx;
    end
  end
endmodule

// File: rtl/bankdec_checker.sv
module bankdec_checker #(
  parameter int NUM_BANKS = 12,
  parameter int IDX_W     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 done_i,
  input logic [NUM_BANKS-1:0] cs_o,
  input logic                 hit_o,
  input logic [2:0]           mach_o,
  input logic [IDX_W-1:0]     bank_o
);
  assert_cs_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o));

  assert_cs_at_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> cs_o[bank_o]);

  assert_miss_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (cs_o == '0 && mach_o == 3'b000 && bank_o == '0));

  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !done_i) |=> ($stable(cs_o) && $stable(hit_o) && $stable(mach_o)
                                 && $stable(bank_o) && !req_ready));

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && done_i) |=> (req_ready && cs_o == '0 && !hit_o));

  assert_idle_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_o == '0 && !hit_o));
endmodule

bind bank_decoder bankdec_checker #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_bankdec_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done_i(done_i), .cs_o(cs_o), .hit_o(hit_o), .mach_o(mach_o), .bank_o(bank_o)
);

// File: tb/test_bank_decoder.sv
module test_bank_decoder;
  localparam int NB = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_opt = 1'b0;
  logic [3:0]  wr_bank = '0;
  logic [31:0] wr_data = '0;
  logic        req_valid = 1'b0, req_bus = 1'b0, done_i = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready, hit_o;
  logic [NB-1:0] cs_o;
  logic [2:0]  mach_o;
  logic [3:0]  bank_o;

  int nchk = 0, nfail = 0;
  logic [31:0] m_base [NB];
  logic [31:0] m_opt  [NB];

  always #10 clk = ~clk;

  bank_decoder i_bank_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_opt(wr_opt), .wr_bank(wr_bank),
    .wr_data(wr_data), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_bus(req_bus), .done_i(done_i), .cs_o(cs_o), .hit_o(hit_o), .mach_o(mach_o),
    .bank_o(bank_o)
  );

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int predict(input logic [31:0] addr, input logic bus);
    for (int i = 0; i < NB; i++) begin
      if (m_base[i][0] && (m_opt[i][3] == bus) &&
          (((addr[31:15] ^ m_base[i][31:15]) & m_opt[i][31:15]) == 17'd0))
        return i;
    end
    return -1;
  endfunction

  task automatic write_reg(input int b, input bit opt, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_opt = opt; wr_bank = 4'(b); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (opt) m_opt[b] = d; else m_base[b] = d;
  endtask

  task automatic start(input logic [31:0] addr, input logic bus, input string tag);
    int w;
    logic [NB-1:0] ecs;
    @(negedge clk);
    check(req_ready == 1'b1, {"R8 ready before request ", tag}, 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_addr = addr; req_bus = bus;
    w = predict(addr, bus);
    @(negedge clk);
    req_valid = 1'b0;
    ecs = (w >= 0) ? (NB'(1) << w) : '0;
    check(cs_o == ecs, {"R2/R5 chip selects ", tag}, 32'(cs_o), 32'(ecs));
    check(hit_o == (w >= 0), {"R2 hit ", tag}, 32'(hit_o), 32'(w >= 0));
    check(mach_o == ((w >= 0) ? m_opt[w][2:0] : 3'b000), {"R6/R7 machine ", tag},
          32'(mach_o), (w >= 0) ? 32'(m_opt[w][2:0]) : 32'd0);
    check(bank_o == ((w >= 0) ? 4'(w) : 4'd0), {"R5/R7 bank ", tag},
          32'(bank_o), (w >= 0) ? 32'(w) : 32'd0);
    check(req_ready == 1'b0, {"R8 busy after accept ", tag}, 32'(req_ready), 32'd0);
  endtask

  task automatic finish_xfer(input int hold, input string tag);
    logic [NB-1:0] cs_s;
    logic [2:0] m_s;
    cs_s = cs_o; m_s = mach_o;
    for (int k = 0; k < hold; k++) begin
      if (k == 0) req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(cs_o == cs_s && mach_o == m_s && !req_ready, {"R8 hold ", tag}, 32'(cs_o), 32'(cs_s));
    end
    done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
    check(cs_o == '0 && !hit_o, {"R9 clear ", tag}, 32'(cs_o), 32'd0);
    check(req_ready == 1'b1, {"R9 ready ", tag}, 32'(req_ready), 32'd1);
  endtask

  task automatic access(input logic [31:0] addr, input logic bus, input int hold, input string tag);
    start(addr, bus, tag);
    finish_xfer(hold, tag);
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NB; i++) begin m_base[i] = '0; m_opt[i] = '0; end
    #25;
    check(cs_o == '0 && !hit_o, "R10 reset outputs", 32'(cs_o), 32'd0);
    check(req_ready == 1'b1, "R10 reset ready", 32'(req_ready), 32'd1);
    rst_n = 1'b1;

    // Directed: bank 2 at 0x4000_0000 size 1 MB, SDRAM, wide bus
    write_reg(2, 1'b0, 32'h4000_0001);
    write_reg(2, 1'b1, 32'hFFF0_0001);
    access(32'h4000_0000, 1'b0, 0, "R2 base");
    access(32'h400F_7FFF, 1'b0, 1, "R2 top edge");
    access(32'h4010_0000, 1'b0, 0, "R2 just outside");
    access(32'h4000_7ABC, 1'b0, 2, "R2 low bits ignored");
    // R4: same address on local bus misses
    access(32'h4000_0000, 1'b1, 0, "R4 wrong bus");
    // R3: bank 1 covers everything but invalid
    write_reg(1, 1'b1, 32'h0000_0003);
    write_reg(1, 1'b0, 32'h0000_0000);
    access(32'h4000_0000, 1'b0, 0, "R3 invalid bank skipped");
    // R5: bank 1 now valid, overlaps bank 2, lowest wins
    write_reg(1, 1'b0, 32'h0000_0001);
    write_reg(1, 1'b1, 32'h0000_0004);
    access(32'h4000_0000, 1'b0, 0, "R5 overlap lowest wins");
    // R6: local bus bank with user machine C
    write_reg(7, 1'b0, 32'h8000_0001);
    write_reg(7, 1'b1, 32'hFFFF_800C);
    access(32'h8000_1234, 1'b1, 0, "R6 user C local");
    // R1: write during a transfer does not disturb it
    start(32'h8000_0000, 1'b1, "R1 before rewrite");
    @(negedge clk);
    wr_en = 1'b1; wr_opt = 1'b1; wr_bank = 4'd7; wr_data = 32'hFFFF_800A;
    @(negedge clk);
    wr_en = 1'b0;
    check(mach_o == 3'b100 && cs_o == NB'(1 << 7), "R1 in-flight unchanged", 32'(mach_o), 32'd4);
    m_opt[7] = 32'hFFFF_800A;
    finish_xfer(1, "R1 rewrite");
    access(32'h8000_0000, 1'b1, 0, "R1 rewrite applied");

    // Random configurations and accesses
    for (int it = 0; it < 40; it++) begin
      for (int n = 0; n < 3; n++) begin
        int b = int'($urandom_range(NB - 1));
        int k = int'($urandom_range(8));
        logic [16:0] msk = ~17'((1 << k) - 1);
        write_reg(b, 1'b0, {17'($urandom), 14'd0, 1'($urandom_range(3) != 0)});
        write_reg(b, 1'b1, {msk, 11'd0, 1'($urandom), 3'($urandom_range(4))});
      end
      for (int a = 0; a < 6; a++) begin
        int b = int'($urandom_range(NB - 1));
        logic [31:0] ad;
        if ($urandom_range(3) != 0)
          ad = {m_base[b][31:15] ^ (17'($urandom) & ~m_opt[b][31:15]), 15'($urandom)};
        else
          ad = $urandom;
        access(ad, ($urandom_range(3) != 0) ? m_opt[b][3] : 1'($urandom),
               int'($urandom_range(3)), "random R2 R4 R5 R6");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule